// File: doc/BRIEF.md
# Two-Level Interrupt Aggregation Controller

This block gathers interrupt events from several sources into two 32-bit main cause words, a low word and a high word, and drives four interrupt request lines from them. The low word holds sticky bits set by DMA-completion and timer-expiry level inputs. The high word is built from summaries of two second-level cause registers. The first is a 32-bit pin cause register, whose masked byte groups each feed one summary bit. The second is a serial-DMA cause register holding two four-event channels, each of which feeds one summary bit.

Each request line has its own low mask and high mask. It also has a read-only merged view that returns either the low or the high cause word in one read, with two flag bits that tell the handler which half it got and whether the other half also needs service. Software reaches every mask and cause word over a simple single-cycle register bus. A write to a cause register clears the bits written as 0.

Top module: `irq_aggregator`

## Requirements
- R1: After synchronous reset all cause and mask registers read 0, every merged view reads 0 and `irq_out` is 0.
- R2: `dma_done[i]` sets low cause bit 4+i and `timer_exp[i]` sets low cause bit 8+i. The bits stay set after the input drops, and all other low cause bits read 0.
- R3: A write to the low cause (0x0004), pin cause (0xF108) or serial-DMA cause (0xB800) register clears each bit written as 0 and keeps each bit written as 1. A source event in the same cycle as the write sets its bit anyway.
- R4: High cause bit 24+g equals the OR of (pin cause AND pin mask at 0xF10C) over bits 8g..8g+7, for g = 0..3.
- R5: `sdma_evt[4n+k]` sets serial-DMA cause bit 8n+k. High cause bit 4 is the OR of masked cause bits [3:0], and bit 6 is the OR of masked cause bits [11:8]. The mask is at 0xB880.
- R6: The high cause word at 0x000C ignores bus writes, and all of its bits other than 4, 6 and 24-27 read 0.
- R7: `irq_out[k]` goes to 1 exactly one clock after (low cause AND low mask k) or (high cause AND high mask k) becomes nonzero, and to 0 one clock after both become zero.
- R8: For output k the merged view at 0x0024+0x20k reads as follows. If only the high half has masked activity, it returns high cause [29:0] with bit 30 set. Otherwise it returns low cause [29:0], with bit 31 set only when both halves have masked activity.
- R9: For output k the low mask at 0x0014+0x20k and the high mask at 0x001C+0x20k read back the last value written. The merged views ignore writes.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| bus_addr | input | 16 | Register byte address |
| bus_we | input | 1 | Write strobe, one cycle per write |
| bus_wdata | input | 32 | Write data |
| bus_rdata | output | 32 | Read data for `bus_addr`, combinational; 0 for unmapped addresses |
| dma_done | input | 4 | DMA channel completion levels |
| timer_exp | input | 4 | Timer expiry levels |
| pin_evt | input | 32 | Pin event pulses into the pin cause register |
| sdma_evt | input | 8 | Serial-DMA events, four per channel |
| irq_out | output | 4 | Registered interrupt request lines |

## Verification
The case that is hardest to reach from the ports is the merged view reporting "high only" while the low cause word is nonzero. To reach it, the low word has to hold bits that the output's low mask excludes, while a pin group survives both the pin mask and the high mask. The vector table sets up exactly that case, alongside the both-halves and no-activity cases. A directed test also drives a source event in the same cycle as a clearing write, so that it lands on the write's edge.

// File: rtl/irq_agg_pkg.sv
package irq_agg_pkg;

    localparam int DW        = 32;
    localparam int AW        = 16;
    localparam int NOUT      = 4;
    localparam int NDMA      = 4;
    localparam int NTMR      = 4;
    localparam int NSDMA     = 2;
    localparam int SDMA_EVTS = 4;
    localparam int SDMA_STRIDE = 8;
    localparam int NGROUPS   = 4;
    localparam int GROUP_W   = DW / NGROUPS;

    localparam int LO_DMA_POS  = 4;
    localparam int LO_TMR_POS  = 8;
    localparam int HI_PIN_POS  = 24;
    localparam int HI_SDMA_POS = 4;
    localparam int SEL_HI_BIT  = 30;
    localparam int SEL_BOTH_BIT = 31;

    localparam logic [AW-1:0] A_LO_CAUSE = 16'h0004;
    localparam logic [AW-1:0] A_HI_CAUSE = 16'h000C;
    localparam logic [AW-1:0] A_OUT_BASE = 16'h0014;
    localparam logic [AW-1:0] A_OUT_STEP = 16'h0020;
    localparam logic [AW-1:0] A_PIN_CAUSE = 16'hF108;
    localparam logic [AW-1:0] A_PIN_MASK  = 16'hF10C;
    localparam logic [AW-1:0] A_SDMA_CAUSE = 16'hB800;
    localparam logic [AW-1:0] A_SDMA_MASK  = 16'hB880;

    localparam logic [DW-1:0] PAYLOAD = 32'h3FFF_FFFF;

    typedef enum logic [2:0] {
        K_NONE, K_LO, K_HI, K_PIN, K_PMASK, K_SCAUSE, K_SMASK, K_OUT
    } reg_kind_e;

    typedef enum logic [1:0] { S_MLO, S_MHI, S_SEL } out_sub_e;

    typedef struct packed {
        reg_kind_e kind;
        logic [1:0] idx;
        out_sub_e  sub;
    } reg_sel_t;

    function automatic logic [DW-1:0] lo_live();
        logic [DW-1:0] m;
        m = '0;
        for (int i = 0; i < NDMA; i++) m[LO_DMA_POS+i] = 1'b1;
        for (int i = 0; i < NTMR; i++) m[LO_TMR_POS+i] = 1'b1;
        return m;
    endfunction

    function automatic logic [DW-1:0] sdma_live();
        logic [DW-1:0] m;
        m = '0;
        for (int n = 0; n < NSDMA; n++)
            for (int k = 0; k < SDMA_EVTS; k++)
                m[SDMA_STRIDE*n+k] = 1'b1;
        return m;
    endfunction

    function automatic reg_sel_t decode(input logic [AW-1:0] a);
        reg_sel_t r;
        logic [AW-1:0] base;
        r = '{kind: K_NONE, idx: 2'd0, sub: S_MLO};
        case (a)
            A_LO_CAUSE:   r.kind = K_LO;
            A_HI_CAUSE:   r.kind = K_HI;
            A_PIN_CAUSE:  r.kind = K_PIN;
            A_PIN_MASK:   r.kind = K_PMASK;
            A_SDMA_CAUSE: r.kind = K_SCAUSE;
            A_SDMA_MASK:  r.kind = K_SMASK;
            default: begin
                for (int k = 0; k < NOUT; k++) begin
                    base = A_OUT_BASE + AW'(k) * A_OUT_STEP;
                    if (a == base)       begin r.kind = K_OUT; r.idx = 2'(k); r.sub = S_MLO; end
                    if (a == base + 16'd8)  begin r.kind = K_OUT; r.idx = 2'(k); r.sub = S_MHI; end
                    if (a == base + 16'd16) begin r.kind = K_OUT; r.idx = 2'(k); r.sub = S_SEL; end
                end
            end
        endcase
        return r;
    endfunction

    function automatic logic [DW-1:0] merge_sel(input logic [DW-1:0] lo, input logic [DW-1:0] hi,
                                                input logic [DW-1:0] mlo, input logic [DW-1:0] mhi);
        logic lo_act, hi_act;
        logic [DW-1:0] r;
        lo_act = |(lo & mlo);
        hi_act = |(hi & mhi);
        if (!lo_act && hi_act) begin
            r = hi & PAYLOAD;
            r[SEL_HI_BIT] = 1'b1;
        end else begin
            r = lo & PAYLOAD;
            r[SEL_BOTH_BIT] = lo_act && hi_act;
        end
        return r;
    endfunction

endpackage

// File: rtl/irq_cause_reg.sv
module irq_cause_reg #(
    parameter int W = 32,
    parameter logic [W-1:0] LIVE = '1
) (
    input  logic         clk,
    input  logic         rst,
    input  logic         wr_en,
    input  logic [W-1:0] wdata,
    input  logic [W-1:0] set,
    output logic [W-1:0] q
);
    logic [W-1:0] keep;
    logic [W-1:0] q_n;

    always_comb begin
        keep = wr_en ? wdata : '1;
        q_n  = ((q & keep) | set) & LIVE;
    end

    always_ff @(posedge clk) begin
        if (rst) q <= '0;
        else     q <= q_n;
    end
endmodule

// File: rtl/irq_summary.sv
module irq_summary
    import irq_agg_pkg::*;
(
    input  logic [DW-1:0] pin_cause,
    input  logic [DW-1:0] pin_mask,
    input  logic [DW-1:0] sdma_cause,
    input  logic [DW-1:0] sdma_mask,
    output logic [DW-1:0] hi_cause
);
    logic [NGROUPS-1:0] grp_act;
    logic [NSDMA-1:0]   ch_act;
    logic [DW-1:0]      pin_m;
    logic [DW-1:0]      sdma_m;

    assign pin_m  = pin_cause & pin_mask;
    assign sdma_m = sdma_cause & sdma_mask;

    for (genvar g = 0; g < NGROUPS; g++) begin : g_pin
        assign grp_act[g] = |pin_m[GROUP_W*g +: GROUP_W];
    end

    for (genvar n = 0; n < NSDMA; n++) begin : g_sdma
        assign ch_act[n] = |sdma_m[SDMA_STRIDE*n +: SDMA_EVTS];
    end

    always_comb begin
        hi_cause = '0;
        for (int g = 0; g < NGROUPS; g++) hi_cause[HI_PIN_POS+g] = grp_act[g];
        for (int n = 0; n < NSDMA; n++)   hi_cause[HI_SDMA_POS+2*n] = ch_act[n];
    end
endmodule

// File: rtl/irq_out_unit.sv
module irq_out_unit
    import irq_agg_pkg::*;
(
    input  logic          clk,
    input  logic          rst,
    input  logic [DW-1:0] lo_cause,
    input  logic [DW-1:0] hi_cause,
    input  logic          mlo_we,
    input  logic          mhi_we,
    input  logic [DW-1:0] wdata,
    output logic [DW-1:0] mask_lo,
    output logic [DW-1:0] mask_hi,
    output logic [DW-1:0] sel,
    output logic          irq
);
    logic req;

    assign req = (|(lo_cause & mask_lo)) || (|(hi_cause & mask_hi));
    assign sel = merge_sel(lo_cause, hi_cause, mask_lo, mask_hi);

    always_ff @(posedge clk) begin
        if (rst) begin
            mask_lo <= '0;
            mask_hi <= '0;
            irq     <= 1'b0;
        end else begin
            if (mlo_we) mask_lo <= wdata;
            if (mhi_we) mask_hi <= wdata;
            irq <= req;
        end
    end
endmodule

// File: rtl/irq_aggregator.sv
module irq_aggregator
    import irq_agg_pkg::*;
(
    input  logic          clk,
    input  logic          rst,
    input  logic [AW-1:0] bus_addr,
    input  logic          bus_we,
    input  logic [DW-1:0] bus_wdata,
    output logic [DW-1:0] bus_rdata,
    input  logic [NDMA-1:0] dma_done,
    input  logic [NTMR-1:0] timer_exp,
    input  logic [DW-1:0] pin_evt,
    input  logic [NSDMA*SDMA_EVTS-1:0] sdma_evt,
    output logic [NOUT-1:0] irq_out
);
    reg_sel_t rs;
    logic [DW-1:0] lo_set, sdma_set;
    logic [DW-1:0] lo_cause, hi_cause, pin_cause, sdma_cause;
    logic [DW-1:0] pin_mask, sdma_mask;
    logic [NOUT-1:0][DW-1:0] mask_lo_all, mask_hi_all, sel_all;

    assign rs = decode(bus_addr);

    always_comb begin
        lo_set = '0;
        for (int i = 0; i < NDMA; i++) lo_set[LO_DMA_POS+i] = dma_done[i];
        for (int i = 0; i < NTMR; i++) lo_set[LO_TMR_POS+i] = timer_exp[i];
        sdma_set = '0;
        for (int n = 0; n < NSDMA; n++)
            for (int k = 0; k < SDMA_EVTS; k++)
                sdma_set[SDMA_STRIDE*n+k] = sdma_evt[SDMA_EVTS*n+k];
    end

    irq_cause_reg #(.W(DW), .LIVE(lo_live())) u_lo (
        .clk(clk), .rst(rst), .wr_en(bus_we && rs.kind == K_LO),
        .wdata(bus_wdata), .set(lo_set), .q(lo_cause));

    irq_cause_reg #(.W(DW), .LIVE('1)) u_pin (
        .clk(clk), .rst(rst), .wr_en(bus_we && rs.kind == K_PIN),
        .wdata(bus_wdata), .set(pin_evt), .q(pin_cause));

    irq_cause_reg #(.W(DW), .LIVE(sdma_live())) u_sdma (
        .clk(clk), .rst(rst), .wr_en(bus_we && rs.kind == K_SCAUSE),
        .wdata(bus_wdata), .set(sdma_set), .q(sdma_cause));

    always_ff @(posedge clk) begin
        if (rst) begin
            pin_mask  <= '0;
            sdma_mask <= '0;
        end else if (bus_we) begin
            if (rs.kind == K_PMASK) pin_mask  <= bus_wdata;
            if (rs.kind == K_SMASK) sdma_mask <= bus_wdata;
        end
    end

    irq_summary u_sum (
        .pin_cause(pin_cause), .pin_mask(pin_mask),
        .sdma_cause(sdma_cause), .sdma_mask(sdma_mask),
        .hi_cause(hi_cause));

    for (genvar k = 0; k < NOUT; k++) begin : g_out
        irq_out_unit u_unit (
            .clk(clk), .rst(rst),
            .lo_cause(lo_cause), .hi_cause(hi_cause),
            .mlo_we(bus_we && rs.kind == K_OUT && rs.idx == 2'(k) && rs.sub == S_MLO),
            .mhi_we(bus_we && rs.kind == K_OUT && rs.idx == 2'(k) && rs.sub == S_MHI),
            .wdata(bus_wdata),
            .mask_lo(mask_lo_all[k]), .mask_hi(mask_hi_all[k]),
            .sel(sel_all[k]), .irq(irq_out[k]));
    end

    always_comb begin
        case (rs.kind)
            K_LO:     bus_rdata = lo_cause;
            K_HI:     bus_rdata = hi_cause;
            K_PIN:    bus_rdata = pin_cause;
            K_PMASK:  bus_rdata = pin_mask;
            K_SCAUSE: bus_rdata = sdma_cause;
            K_SMASK:  bus_rdata = sdma_mask;
            K_OUT: begin
                case (rs.sub)
                    S_MLO:   bus_rdata = mask_lo_all[rs.idx];
                    S_MHI:   bus_rdata = mask_hi_all[rs.idx];
                    default: bus_rdata = sel_all[rs.idx];
                endcase
            end
            default:  bus_rdata = '0;
        endcase
    end
endmodule

// File: rtl/irq_aggregator_chk.sv
module irq_aggregator_chk
    import irq_agg_pkg::*;
(
    input logic          clk,
    input logic          rst,
    input logic          bus_we,
    input logic [AW-1:0] bus_addr,
    input logic [DW-1:0] pin_evt,
    input logic [NOUT-1:0] irq_out,
    input logic [DW-1:0] lo_cause,
    input logic [DW-1:0] hi_cause,
    input logic [DW-1:0] pin_cause,
    input logic [DW-1:0] pin_mask,
    input logic [NOUT-1:0][DW-1:0] mask_lo_all,
    input logic [NOUT-1:0][DW-1:0] mask_hi_all,
    input logic [NOUT-1:0][DW-1:0] sel_all
);
    a_r1_reset_quiet: assert property (@(posedge clk) rst |=> (irq_out == '0 && lo_cause == '0));

    a_r2_lo_sticky: assert property (@(posedge clk) disable iff (rst)
        !(bus_we && bus_addr == A_LO_CAUSE) |=> ((lo_cause & $past(lo_cause)) == $past(lo_cause)));

    a_r3_event_wins: assert property (@(posedge clk) disable iff (rst)
        (pin_evt != '0) |=> ((pin_cause & $past(pin_evt)) == $past(pin_evt)));

    a_r4_no_masked_pins: assert property (@(posedge clk) disable iff (rst)
        ((pin_cause & pin_mask) == '0) |-> (hi_cause[HI_PIN_POS +: NGROUPS] == '0));

    a_r6_hi_unused_zero: assert property (@(posedge clk) disable iff (rst)
        (hi_cause & ~32'h0F00_0050) == '0);

    for (genvar k = 0; k < NOUT; k++) begin : g_k
        a_r7_irq_latency: assert property (@(posedge clk) disable iff (rst)
            1'b1 |=> (irq_out[k] == $past(((lo_cause & mask_lo_all[k]) != '0) ||
                                          ((hi_cause & mask_hi_all[k]) != '0))));
        a_r8_flags_exclusive: assert property (@(posedge clk) disable iff (rst)
            !(sel_all[k][SEL_HI_BIT] && sel_all[k][SEL_BOTH_BIT]));
    end
endmodule

bind irq_aggregator irq_aggregator_chk u_chk (
    .clk(clk), .rst(rst), .bus_we(bus_we), .bus_addr(bus_addr),
    .pin_evt(pin_evt), .irq_out(irq_out),
    .lo_cause(lo_cause), .hi_cause(hi_cause),
    .pin_cause(pin_cause), .pin_mask(pin_mask),
    .mask_lo_all(mask_lo_all), .mask_hi_all(mask_hi_all), .sel_all(sel_all));

// File: tb/irq_aggregator_bench.sv
`timescale 1ns/1ps
module irq_aggregator_bench;
    import irq_agg_pkg::*;

    logic clk = 1'b0;
    logic rst = 1'b1;
    logic [AW-1:0] bus_addr = '0;
    logic bus_we = 1'b0;
    logic [DW-1:0] bus_wdata = '0;
    logic [DW-1:0] bus_rdata;
    logic [3:0] dma_done = '0;
    logic [3:0] timer_exp = '0;
    logic [DW-1:0] pin_evt = '0;
    logic [7:0] sdma_evt = '0;
    logic [3:0] irq_out;

    int checks = 0;
    int errors = 0;
    bit done = 0;

    always #2 clk = ~clk;

    irq_aggregator u_irq_aggregator (
        .clk(clk), .rst(rst), .bus_addr(bus_addr), .bus_we(bus_we),
        .bus_wdata(bus_wdata), .bus_rdata(bus_rdata),
        .dma_done(dma_done), .timer_exp(timer_exp), .pin_evt(pin_evt),
        .sdma_evt(sdma_evt), .irq_out(irq_out));

    typedef struct packed {
        logic [7:0]  src;
        logic [31:0] pin;
        logic [31:0] pmask;
        logic [31:0] mlo;
        logic [31:0] mhi;
        logic [31:0] sel;
        logic        irq;
    } vec_t;

    localparam int NV = 6;
    localparam vec_t VEC [NV] = '{
        '{8'h01, 32'h0000_0000, 32'h0000_0000, 32'h0000_0010, 32'h0000_0000, 32'h0000_0010, 1'b1},
        '{8'h00, 32'h0000_0100, 32'h0000_0100, 32'h0000_0000, 32'h0200_0000, 32'h4200_0000, 1'b1},
        '{8'h10, 32'h0100_0000, 32'hFF00_0000, 32'h0000_0100, 32'h0800_0000, 32'h8000_0100, 1'b1},
        '{8'h02, 32'h0000_0001, 32'h0000_0001, 32'h0000_0010, 32'h0200_0000, 32'h0000_0020, 1'b0},
        '{8'h80, 32'h0001_0000, 32'h00FF_0000, 32'h0000_0000, 32'h0400_0000, 32'h4400_0000, 1'b1},
        '{8'h00, 32'hFFFF_FFFF, 32'h0000_0000, 32'h0000_0000, 32'h0F00_0000, 32'h0000_0000, 1'b0}
    };

    task automatic check(input string req, input logic [31:0] act, input logic [31:0] exp);
        checks++;
        if (act !== exp) begin
            errors++;
            $display("FAIL %s actual=%08h expected=%08h", req, act, exp);
        end
    endtask

    task automatic wr(input logic [15:0] a, input logic [31:0] d);
        @(negedge clk);
        bus_addr = a; bus_wdata = d; bus_we = 1'b1;
        @(negedge clk);
        bus_we = 1'b0;
    endtask

    task automatic rd(input logic [15:0] a, output logic [31:0] d);
        @(negedge clk);
        bus_addr = a;
        #0.5;
        d = bus_rdata;
    endtask

    task automatic pulse(input logic [7:0] src, input logic [31:0] pin, input logic [7:0] sd);
        @(negedge clk);
        dma_done = src[3:0]; timer_exp = src[7:4]; pin_evt = pin; sdma_evt = sd;
        @(negedge clk);
        dma_done = '0; timer_exp = '0; pin_evt = '0; sdma_evt = '0;
    endtask

    task automatic clear_all();
        wr(A_LO_CAUSE, 32'h0);
        wr(A_PIN_CAUSE, 32'h0);
        wr(A_SDMA_CAUSE, 32'h0);
        wr(A_PIN_MASK, 32'h0);
        wr(A_SDMA_MASK, 32'h0);
    endtask

    initial begin
        #400000;
        if (!done) begin
            errors++;
            $display("FAIL watchdog expired");
            $display("CHECKS %0d ERRORS %0d", checks, errors);
            $finish;
        end
    end

    initial begin
        logic [31:0] r;
        repeat (3) @(negedge clk);
        rst = 1'b0;

        // R1 reset state
        rd(A_LO_CAUSE, r);  check("R1 lo cause", r, 0);
        rd(A_HI_CAUSE, r);  check("R1 hi cause", r, 0);
        rd(A_PIN_CAUSE, r); check("R1 pin cause", r, 0);
        rd(16'h0074, r);    check("R1 mask lo3", r, 0);
        rd(16'h0084, r);    check("R1 sel3", r, 0);
        check("R1 irq", {28'h0, irq_out}, 0);

        // R8 and R4 table
        for (int i = 0; i < NV; i++) begin
            clear_all();
            wr(A_PIN_MASK, VEC[i].pmask);
            wr(16'h0014, VEC[i].mlo);
            wr(16'h001C, VEC[i].mhi);
            pulse(VEC[i].src, VEC[i].pin, 8'h00);
            repeat (2) @(negedge clk);
            rd(16'h0024, r);
            check($sformatf("R8 sel0 vec %0d", i), r, VEC[i].sel);
            check($sformatf("R7 irq0 vec %0d", i), {31'h0, irq_out[0]}, {31'h0, VEC[i].irq});
        end
        wr(16'h0014, 32'h0);
        wr(16'h001C, 32'h0);

        // R4 group summary readback
        clear_all();
        wr(A_PIN_MASK, 32'h00FF_00FF);
        pulse(8'h00, 32'h0101_0101, 8'h00);
        rd(A_HI_CAUSE, r); check("R4 hi groups 0,2", r, 32'h0500_0000);

        // R9 mask readback and sel ignores writes
        wr(16'h007C, 32'hA5A5_5A5A);
        rd(16'h007C, r); check("R9 mask hi3", r, 32'hA5A5_5A5A);
        wr(16'h0054, 32'h1234_5678);
        rd(16'h0054, r); check("R9 mask lo2", r, 32'h1234_5678);
        wr(16'h0044, 32'hFFFF_FFFF);
        rd(16'h0034, r); check("R9 mask lo1 untouched by sel write", r, 0);
        rd(16'h0044, r); check("R9 sel1 unchanged", r, 0);
        wr(16'h007C, 32'h0);
        wr(16'h0054, 32'h0);

        // R2 sticky low cause and unused bits
        clear_all();
        pulse(8'h41, 32'h0, 8'h00);
        repeat (2) @(negedge clk);
        rd(A_LO_CAUSE, r); check("R2 lo sticky", r, 32'h0000_0410);
        wr(A_LO_CAUSE, 32'hFFFF_FFFF);
        rd(A_LO_CAUSE, r); check("R2 lo unused bits zero", r, 32'h0000_0410);

        // R3 clear semantics
        clear_all();
        pulse(8'h00, 32'h0000_00F0, 8'h00);
        wr(A_PIN_CAUSE, 32'hFFFF_FF3F);
        rd(A_PIN_CAUSE, r); check("R3 write-0 clears", r, 32'h0000_0030);
        @(negedge clk);
        bus_addr = A_PIN_CAUSE; bus_wdata = 32'h0; bus_we = 1'b1; pin_evt = 32'h0000_0080;
        @(negedge clk);
        bus_we = 1'b0; pin_evt = '0;
        rd(A_PIN_CAUSE, r); check("R3 event beats clear", r, 32'h0000_0080);
        @(negedge clk);
        bus_addr = A_LO_CAUSE; bus_wdata = 32'h0; bus_we = 1'b1; dma_done = 4'h4;
        @(negedge clk);
        bus_we = 1'b0; dma_done = '0;
        rd(A_LO_CAUSE, r); check("R3 lo event beats clear", r, 32'h0000_0040);

        // R5 serial DMA
        clear_all();
        wr(A_SDMA_MASK, 32'h0000_0200);
        pulse(8'h00, 32'h0, 8'h20);
        rd(A_SDMA_CAUSE, r); check("R5 sdma cause ch1", r, 32'h0000_0200);
        rd(A_HI_CAUSE, r);   check("R5 hi bit6", r, 32'h0000_0040);
        pulse(8'h00, 32'h0, 8'h01);
        rd(A_HI_CAUSE, r);   check("R5 ch0 masked off", r, 32'h0000_0040);
        wr(A_SDMA_MASK, 32'h0000_0201);
        rd(A_HI_CAUSE, r);   check("R5 hi bits 4 and 6", r, 32'h0000_0050);

        // R6 high cause ignores writes
        wr(A_HI_CAUSE, 32'h0);
        rd(A_HI_CAUSE, r);   check("R6 hi write 0 ignored", r, 32'h0000_0050);
        clear_all();
        wr(A_HI_CAUSE, 32'hFFFF_FFFF);
        rd(A_HI_CAUSE, r);   check("R6 hi write 1s ignored", r, 0);

        // R7 registered latency
        clear_all();
        pulse(8'h01, 32'h0, 8'h00);
        @(negedge clk);
        check("R7 irq1 idle", {31'h0, irq_out[1]}, 0);
        @(negedge clk);
        bus_addr = 16'h0034; bus_wdata = 32'h10; bus_we = 1'b1;
        @(negedge clk);
        bus_we = 1'b0;
        #0.5;
        check("R7 irq1 not yet", {31'h0, irq_out[1]}, 0);
        @(negedge clk);
        #0.5;
        check("R7 irq1 one clock later", {31'h0, irq_out[1]}, 1);
        wr(A_LO_CAUSE, 32'h0);
        #0.5;
        check("R7 irq1 still set", {31'h0, irq_out[1]}, 1);
        @(negedge clk);
        #0.5;
        check("R7 irq1 drops", {31'h0, irq_out[1]}, 0);

        // R1 reset again after activity
        pulse(8'hFF, 32'hFFFF_FFFF, 8'hFF);
        @(negedge clk); rst = 1'b1;
        @(negedge clk); rst = 1'b0;
        rd(A_LO_CAUSE, r);   check("R1 lo after reset", r, 0);
        rd(A_SDMA_CAUSE, r); check("R1 sdma after reset", r, 0);
        rd(16'h0034, r);     check("R1 mask lo1 after reset", r, 0);
        check("R1 irq after reset", {28'h0, irq_out}, 0);

        done = 1;
        $display("CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end
endmodule